// File: doc/BRIEF.md
# Receive Character Buffer with Error Tracking

This block sits between a serial receiver and the host-facing register logic of a UART channel. Each received byte enters a 16-deep first-in first-out store together with three per-character error flags: break, framing and parity. The host sees the oldest byte on a show-ahead data port and pops it with a read strobe. An eight-bit channel status word is presented continuously. Its upper three bits describe receive errors, and the lower bits report overrun, two transmitter conditions passed through from the transmit side, buffer full and data available.

A mode input selects how the error bits behave. In per-character mode they follow the byte at the head of the buffer, so they vanish once that byte is read. In accumulating mode they collect every error seen since the last clear, and they remain set after the offending bytes have left. A small command port clears the error state or resets the whole receive side.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the buffer is empty, `rdData` is 0 and status bits 7, 6, 5, 4, 1 and 0 are all 0.
- R2: Status bit 3 equals `txEmpty` and bit 2 equals `txReady`. Bit 0 is 1 exactly when the buffer holds at least one byte. Bit 1 is 1 exactly when it holds 16 bytes.
- R3: Bytes come out in the order they were accepted. `rdData` shows the oldest byte (0 when empty), and each `rdStrobe` on a non-empty buffer removes it. A write and a read in the same cycle both take effect.
- R4: With `blockMode` low, status bits 7, 6 and 5 are the break, framing and parity flags of the head byte. They read 0 when the buffer is empty and change to the next byte's flags when the head is read.
- R5: With `blockMode` high, status bits 7, 6 and 5 are the OR of the break, framing and parity flags of every byte accepted since the last error clear. They stay set after those bytes are read.
- R6: A write while the buffer holds 16 bytes, with no read in the same cycle, is dropped and sets status bit 4 (overrun). A pulse on `ovrIn` also sets it. Overrun stays set in both modes until an error clear or a receiver reset.
- R7: Command code 0x4 on `cmdCode` with `cmdValid` high clears overrun and the accumulated error bits. With `blockMode` low it also clears the flags of the current head byte. Buffered bytes are kept.
- R8: Command code 0x2 flushes the buffer and clears every error bit. It takes priority over a write, a read or an `ovrIn` pulse in the same cycle.
- R9: A read strobe on an empty buffer changes nothing: the buffer stays empty and overrun is unchanged.
- R10: A write arriving while the buffer is full, in the same cycle as a read, is accepted and does not set overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Received byte valid this cycle |
| wrData | input | 8 | Received byte |
| wrBreak | input | 1 | Break flag for the received byte |
| wrFrame | input | 1 | Framing error flag for the received byte |
| wrParity | input | 1 | Parity error flag for the received byte |
| ovrIn | input | 1 | Overrun event reported by the receiver |
| rdStrobe | input | 1 | Pop the head byte |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 4 | Command code: 0x4 clears errors, 0x2 resets the receiver |
| blockMode | input | 1 | 1 selects accumulating errors, 0 selects per-character errors |
| txEmpty | input | 1 | Transmitter empty, shown in status bit 3 |
| txReady | input | 1 | Transmitter ready, shown in status bit 2 |
| rdData | output | 8 | Head byte, 0 when empty |
| status | output | 8 | Channel status word |

## Verification
The properties assume that commands arrive as single-cycle strobes carrying one code, and that `blockMode` only changes between operations. The clear-related properties hold only in cycles with no competing write or `ovrIn` pulse, so they are guarded on those inputs being low. The stimulus drives one operation per cycle from a vector table. It changes mode only on idle or command cycles, and it raises simultaneous write, read and command strobes only in the directed cases that test priority.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [3:0] CMD_RX_RESET  = 4'h2;
  localparam logic [3:0] CMD_ERR_RESET = 4'h4;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } errFlags_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic clrErr;
    logic clrHead;
    logic setOvr;
  } ctlStrobes_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          rdStrobe,
  input  logic          cmdValid,
  input  logic [3:0]    cmdCode,
  input  logic          blockMode,
  input  logic          ovrIn,
  output ctlStrobes_t   strobes,
  output logic [PW-1:0] wrIdx,
  output logic [PW-1:0] rdIdx,
  output logic          isEmpty,
  output logic          isFull
);
  logic [CW-1:0] count;
  logic rxReset, errReset;

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CW'(DEPTH));
  assign rxReset  = cmdValid && (cmdCode == CMD_RX_RESET);
  assign errReset = cmdValid && (cmdCode == CMD_ERR_RESET);

  always_comb begin
    strobes.flush   = rxReset;
    strobes.pop     = rdStrobe && !isEmpty && !rxReset;
    strobes.push    = wrValid && (!isFull || strobes.pop) && !rxReset;
    strobes.setOvr  = !rxReset && (ovrIn || (wrValid && isFull && !strobes.pop));
    strobes.clrErr  = errReset;
    strobes.clrHead = errReset && !blockMode && !isEmpty && !strobes.pop;
  end

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else if (strobes.flush) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrIdx <= bump(wrIdx);
      if (strobes.pop)  rdIdx <= bump(rdIdx);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxf_data.sv
module rxf_data
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strobes,
  input  logic [PW-1:0] wrIdx,
  input  logic [PW-1:0] rdIdx,
  input  logic [DW-1:0] wrData,
  input  errFlags_t     wrFlags,
  input  logic          isEmpty,
  input  logic          blockMode,
  output logic [DW-1:0] headData,
  output errFlags_t     errView,
  output logic          ovrFlag
);
  logic [DW-1:0] dataMem [DEPTH];
  errFlags_t     flagMem [DEPTH];
  errFlags_t     sticky;

  always_ff @(posedge clk) begin
    if (strobes.push) dataMem[wrIdx] <= wrData;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flagMem[g] <= '0;
        end else if (strobes.push && (wrIdx == PW'(g))) begin
          flagMem[g] <= wrFlags;
        end else if (strobes.clrHead && (rdIdx == PW'(g))) begin
          flagMem[g] <= '0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sticky  <= '0;
      ovrFlag <= 1'b0;
    end else if (strobes.flush) begin
      sticky  <= '0;
      ovrFlag <= 1'b0;
    end else begin
      sticky  <= (strobes.clrErr ? errFlags_t'('0) : sticky)
               | (strobes.push ? wrFlags : errFlags_t'('0));
      ovrFlag <= (ovrFlag && !strobes.clrErr) || strobes.setOvr;
    end
  end

  assign headData = isEmpty ? '0 : dataMem[rdIdx];
  assign errView  = blockMode ? sticky : (isEmpty ? errFlags_t'('0) : flagMem[rdIdx]);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       wrBreak,
  input  logic       wrFrame,
  input  logic       wrParity,
  input  logic       ovrIn,
  input  logic       rdStrobe,
  input  logic       cmdValid,
  input  logic [3:0] cmdCode,
  input  logic       blockMode,
  input  logic       txEmpty,
  input  logic       txReady,
  output logic [7:0] rdData,
  output logic [7:0] status
);
  ctlStrobes_t   strobes;
  logic [PW-1:0] wrIdx, rdIdx;
  logic          isEmpty, isFull, ovrFlag;
  errFlags_t     errView, wrFlags;

  assign wrFlags = '{brk: wrBreak, frm: wrFrame, par: wrParity};

  rxf_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .blockMode(blockMode),
    .ovrIn(ovrIn), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .isEmpty(isEmpty), .isFull(isFull)
  );

  rxf_data #(.DEPTH(DEPTH), .DW(8)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .wrFlags(wrFlags), .isEmpty(isEmpty),
    .blockMode(blockMode), .headData(rdData), .errView(errView),
    .ovrFlag(ovrFlag)
  );

  assign status = {errView.brk, errView.frm, errView.par, ovrFlag,
                   txEmpty, txReady, isFull, !isEmpty};
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic [7:0] wrData,
  input logic       wrBreak,
  input logic       wrFrame,
  input logic       wrParity,
  input logic       ovrIn,
  input logic       rdStrobe,
  input logic       cmdValid,
  input logic [3:0] cmdCode,
  input logic       blockMode,
  input logic       txEmpty,
  input logic       txReady,
  input logic [7:0] rdData,
  input logic [7:0] status
);
  logic rxRst, errRst;
  assign rxRst  = cmdValid && (cmdCode == 4'h2);
  assign errRst = cmdValid && (cmdCode == 4'h4);

  assert_full_has_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |-> status[0]);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (status[1] && wrValid && !rdStrobe && !rxRst) |=> status[4]);

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errRst && !wrValid && !ovrIn) |=> (!status[4] && (!blockMode || status[7:5] == 3'b000)));

  assert_rx_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxRst |=> (status[7:4] == 4'h0 && status[1:0] == 2'b00 && rdData == 8'h00));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!status[0] && rdStrobe && !wrValid && !cmdValid && !ovrIn) |=> (!status[0] && $stable(status[4])));

  assert_full_rw_R10: assert property (@(posedge clk) disable iff (!rstN)
    (status[1] && wrValid && rdStrobe && !cmdValid && !ovrIn && !status[4]) |=> (status[1] && !status[4]));
endmodule

bind rx_err_fifo rx_err_fifo_chk uChk (.*);

// File: tb/rx_err_fifo_test.sv
module rx_err_fifo_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrValid = 0, wrBreak = 0, wrFrame = 0, wrParity = 0, ovrIn = 0;
  logic rdStrobe = 0, cmdValid = 0, blockMode = 0, txEmpty = 0, txReady = 1;
  logic [7:0] wrData = '0;
  logic [3:0] cmdCode = '0;
  logic [7:0] rdData, status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_err_fifo uut (.*);

  typedef struct packed {
    logic       wr; logic [7:0] d; logic [2:0] f; logic rd;
    logic       cv; logic [3:0] cc; logic bm; logic [3:0] req;
    logic [7:0] es; logic [7:0] ed;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'hA1, 3'b000, 1'b0, 1'b0, 4'h0, 1'b0, 4'd3,  8'h09, 8'hA1}, // R3 first byte
    '{1'b1, 8'hB2, 3'b100, 1'b0, 1'b0, 4'h0, 1'b0, 4'd4,  8'h09, 8'hA1}, // R4 head flags only
    '{1'b1, 8'hC3, 3'b011, 1'b0, 1'b0, 4'h0, 1'b0, 4'd4,  8'h09, 8'hA1}, // R4
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 4'h0, 1'b0, 4'd4,  8'h89, 8'hB2}, // R4 break at head
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 4'h0, 1'b0, 4'd4,  8'h69, 8'hC3}, // R4 frame+parity
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 4'h0, 1'b1, 4'd5,  8'hE9, 8'hC3}, // R5 accumulated
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 4'h0, 1'b1, 4'd5,  8'hE8, 8'h00}, // R5 kept after read
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 4'h4, 1'b1, 4'd7,  8'h08, 8'h00}, // R7 clear
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 4'h0, 1'b1, 4'd9,  8'h08, 8'h00}, // R9 empty read
    '{1'b1, 8'h5A, 3'b010, 1'b0, 1'b0, 4'h0, 1'b1, 4'd5,  8'h49, 8'h5A}, // R5
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 4'h4, 1'b0, 4'd7,  8'h09, 8'h5A}, // R7 head flags cleared
    '{1'b1, 8'h66, 3'b001, 1'b1, 1'b0, 4'h0, 1'b0, 4'd3,  8'h29, 8'h66}, // R3 write+read
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 4'h2, 1'b0, 4'd8,  8'h08, 8'h00}  // R8 flush
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wrValid = 0; rdStrobe = 0; cmdValid = 0; ovrIn = 0;
    wrBreak = 0; wrFrame = 0; wrParity = 0;
  endtask

  task automatic push(input logic [7:0] d);
    wrValid = 1; wrData = d; tick();
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    check("R1 status after reset", status, 8'h04);
    check("R1 data after reset", rdData, 8'h00);
    txEmpty = 1; txReady = 0;
    #1 check("R2 tx bits pass through", status, 8'h08);

    for (int i = 0; i < NV; i++) begin
      wrValid = VECS[i].wr; wrData = VECS[i].d;
      {wrBreak, wrFrame, wrParity} = VECS[i].f;
      rdStrobe = VECS[i].rd; cmdValid = VECS[i].cv; cmdCode = VECS[i].cc;
      blockMode = VECS[i].bm;
      tick();
      check($sformatf("R%0d vector %0d status", VECS[i].req, i), status, VECS[i].es);
      check($sformatf("R%0d vector %0d data", VECS[i].req, i), rdData, VECS[i].ed);
    end

    blockMode = 0;
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    check("R2 full flag", status, 8'h0B);
    push(8'hFF);
    check("R6 overrun on full write", status, 8'h1B);
    check("R6 dropped byte not at head", rdData, 8'h10);
    for (int i = 0; i < 16; i++) begin
      check("R3 order", rdData, 8'h10 + 8'(i));
      rdStrobe = 1; tick();
    end
    check("R6 overrun sticky after drain", status, 8'h18);
    cmdValid = 1; cmdCode = 4'h4; tick();
    check("R7 overrun cleared", status, 8'h08);
    ovrIn = 1; tick();
    check("R6 external overrun", status, 8'h18);
    cmdValid = 1; cmdCode = 4'h4; tick();

    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    wrValid = 1; wrData = 8'h77; rdStrobe = 1; tick();
    check("R10 full write with read", status, 8'h0B);
    check("R10 head advanced", rdData, 8'h11);

    wrValid = 1; wrData = 8'h99; wrBreak = 1; rdStrobe = 1; ovrIn = 1;
    cmdValid = 1; cmdCode = 4'h2; tick();
    check("R8 reset wins status", status, 8'h08);
    check("R8 reset wins data", rdData, 8'h00);
    finish();
  end
endmodule